// File: doc/BRIEF.md
# Ethernet Transmit Status Register

This block keeps the status of a MAC transmitter in one 16-bit read-only word. The transmit and receive engines send it single-cycle event strobes. Each event sets its own flag, and each flag has its own rule for clearing. Some flags clear when software turns transmit enable back on. Some clear at the end of every packet. The rest clear on a receive preamble or on a read of the event counters. Events that end a transmission also request that transmit enable be dropped.

At every packet completion the block captures the current word as a snapshot, which is stored with that packet. Later frames go on updating the live word. The block also carries two real-time bits. One is the link state, taken from a synchronised active-low pin, and any change of it raises an interrupt pulse. The other is a mirror of transmit enable. Receive overrun sets a separate sticky interrupt-status bit, which stays set until the CPU clears it.

Top module: `tx_status_reg`

## Requirements
- R1: When `pkt_done` is high while `txen` is high, the next cycle has `snap_valid` high for one cycle, and `snap_word` holds the `status` value from the `pkt_done` cycle. `snap_word` keeps that value until the next capture.
- R2: `ev_underrun` with `txen` high sets `status[9]` on the next edge and drives `txen_clr` high in the same cycle. The bit stays set until a cycle with `txen_set` high clears it.
- R3: `ev_late_col` with `txen` high sets `status[8]` and drives `txen_clr` in the same cycle. Only `txen_set` clears the bit.
- R4: `ev_lost_carr` sets `status[7]` and drives `txen_clr` only while both `carr_mon_en` and `txen` are high. Only `txen_set` clears the bit.
- R5: The per-packet flags are set by their strobes while `txen` is high, and all of them clear on `pkt_done`. The bit positions are: tx_ok `status[0]`, single collision `[1]`, multiple collisions `[2]`, multicast `[3]`, broadcast `[4]`, deferred `[5]`, excessive deferral `[6]`.
- R6: `status[12]` is the inverse of `link_n_pin` after two synchronising flops. `link_irq` pulses for one cycle in the cycle after each change of `status[12]`.
- R7: `ev_rx_overrun` sets `status[11]`, and `rx_preamble` clears it.
- R8: `ev_rx_overrun` also sets `ovr_int`, which stays high until `ovr_int_clr`.
- R9: `ev_ctr_max` sets `status[10]`, and `ctr_read` clears it.
- R10: While `txen` is low, the transmit strobes and `pkt_done` have no effect: `status[6:0]` holds its value and no snapshot is taken.
- R11: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R12: `status[13]` mirrors `txen`. `status[15:14]` always read 0.
- R13: After a synchronous active-low reset, `status`, `snap_valid`, `txen_clr`, `link_irq` and `ovr_int` are all 0, with `link_n_pin` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txen | input | 1 | Transmit-enable control bit |
| txen_set | input | 1 | Strobe: software sets transmit enable |
| pkt_done | input | 1 | Strobe: transmit packet completed |
| ev_tx_ok | input | 1 | Strobe: frame sent successfully |
| ev_single_col | input | 1 | Strobe: one collision |
| ev_multi_col | input | 1 | Strobe: several collisions |
| ev_multicast | input | 1 | Strobe: frame was multicast |
| ev_broadcast | input | 1 | Strobe: frame was broadcast |
| ev_deferred | input | 1 | Strobe: carrier seen during the gap |
| ev_exc_defer | input | 1 | Strobe: excessive deferral |
| carr_mon_en | input | 1 | Carrier monitoring enable |
| ev_lost_carr | input | 1 | Strobe: no carrier at end of preamble |
| ev_late_col | input | 1 | Strobe: collision after 64 byte times |
| ev_underrun | input | 1 | Strobe: transmit underrun |
| ev_ctr_max | input | 1 | Strobe: an event counter reached 15 |
| ctr_read | input | 1 | Strobe: counter register read |
| ev_rx_overrun | input | 1 | Strobe: receive FIFO overrun |
| rx_preamble | input | 1 | Strobe: valid preamble received |
| ovr_int_clr | input | 1 | Strobe: CPU clears overrun interrupt |
| link_n_pin | input | 1 | Asynchronous active-low link pin |
| status | output | 16 | Live status word |
| snap_word | output | 16 | Status captured at packet completion |
| snap_valid | output | 1 | Snapshot written this cycle |
| txen_clr | output | 1 | Request to drop transmit enable |
| link_irq | output | 1 | Pulse on link-state change |
| ovr_int | output | 1 | Sticky receive-overrun interrupt status |

## Verification
A flag that is stuck, or that clears under the wrong rule, shows on `status` on the first edge after the event or clear that should have moved it. A wrong fatal flag also shows on `txen_clr` in the same cycle as the event. A snapshot taken at the wrong moment puts the wrong word on `snap_word` one cycle after `pkt_done`. A fault in the synchroniser shows as a link bit or `link_irq` that is early or late by whole cycles. The bench compares every output with a reference model on every clock, so any of these faults is caught within a cycle of the first stimulus that exposes it.

// File: rtl/tx_status_pkg.sv
// Package: word width and bit positions of the transmit status word.
// Assumes: all users take bit positions from here only.
package tx_status_pkg;
    localparam int STAT_W  = 16;
    localparam int NPKT    = 7;   // per-packet flags, bits 0..6
    localparam int NFATAL  = 3;   // fatal flags, bits 7..9
    localparam int NMISC   = 3;   // rollover, rx overrun, overrun interrupt
    localparam int B_OK    = 0;
    localparam int B_COL1  = 1;
    localparam int B_COLN  = 2;
    localparam int B_MCAST = 3;
    localparam int B_BCAST = 4;
    localparam int B_DEFR  = 5;
    localparam int B_XDEF  = 6;
    localparam int B_LCAR  = 7;
    localparam int B_LCOL  = 8;
    localparam int B_UNRN  = 9;
    localparam int B_CROL  = 10;
    localparam int B_ROVR  = 11;
    localparam int B_LINK  = 12;
    localparam int B_TXEN  = 13;
endpackage

// File: rtl/tx_status_flag.sv
// Module: bank of W sticky flags, each with its own set and clear.
// Assumes: set and clear are single-cycle strobes; set beats clear.
module tx_status_flag #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        // Purpose: hold one flag, set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_status_link_sync.sv
// Module: synchroniser for the active-low link pin, plus change detection.
// Assumes: the pin is asynchronous; resets to "link down" (pin high).
module tx_status_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic link_ok,
    output logic change
);
    localparam int LAST = STAGES - 1;
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Purpose: shift the pin through the synchronising flops.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin_n};
    end

    // Purpose: remember the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    assign link_ok = ~sync_q[LAST];
    assign change  = sync_q[LAST] ^ prev_q;
endmodule

// File: rtl/tx_status_snap.sv
// Module: captures the status word at packet completion.
// Assumes: capture is a single-cycle strobe already qualified by txen.
module tx_status_snap #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] din,
    output logic [W-1:0] snap_word,
    output logic         snap_valid
);
    // Purpose: latch the word and flag it valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_word  <= '0;
            snap_valid <= 1'b0;
        end else begin
            snap_valid <= capture;
            if (capture) snap_word <= din;
        end
    end
endmodule

// File: rtl/tx_status_reg.sv
// Module: transmit status word of an Ethernet MAC.
// Groups the flags by clear rule, builds the live word, snapshots it at
// packet completion and requests transmit-enable off on fatal events.
// Assumes: all ev_* inputs are one-cycle strobes synchronous to clk.
module tx_status_reg
    import tx_status_pkg::*;
#(
    parameter int LINK_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txen,
    input  logic              txen_set,
    input  logic              pkt_done,
    input  logic              ev_tx_ok,
    input  logic              ev_single_col,
    input  logic              ev_multi_col,
    input  logic              ev_multicast,
    input  logic              ev_broadcast,
    input  logic              ev_deferred,
    input  logic              ev_exc_defer,
    input  logic              carr_mon_en,
    input  logic              ev_lost_carr,
    input  logic              ev_late_col,
    input  logic              ev_underrun,
    input  logic              ev_ctr_max,
    input  logic              ctr_read,
    input  logic              ev_rx_overrun,
    input  logic              rx_preamble,
    input  logic              ovr_int_clr,
    input  logic              link_n_pin,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] snap_word,
    output logic              snap_valid,
    output logic              txen_clr,
    output logic              link_irq,
    output logic              ovr_int
);
    logic [NPKT-1:0]   pkt_set, pkt_clr, pkt_q;
    logic [NFATAL-1:0] fat_set, fat_clr, fat_q;
    logic [NMISC-1:0]  misc_set, misc_clr, misc_q;
    logic              link_ok;

    // Purpose: per-packet strobes, gated by txen, cleared at completion.
    always_comb begin
        pkt_set = {ev_exc_defer, ev_deferred, ev_broadcast, ev_multicast,
                   ev_multi_col, ev_single_col, ev_tx_ok} & {NPKT{txen}};
        pkt_clr = {NPKT{txen & pkt_done}};
    end

    // Purpose: fatal strobes (lost carrier only when monitored), cleared on re-enable.
    always_comb begin
        fat_set = {ev_underrun, ev_late_col, ev_lost_carr & carr_mon_en} & {NFATAL{txen}};
        fat_clr = {NFATAL{txen_set}};
    end

    // Purpose: flags with their own clear strobes: interrupt, overrun, rollover.
    always_comb begin
        misc_set = {ev_rx_overrun, ev_rx_overrun, ev_ctr_max};
        misc_clr = {ovr_int_clr, rx_preamble, ctr_read};
    end

    tx_status_flag #(.W(NPKT)) u_pkt (
        .clk(clk), .rst_n(rst_n), .set(pkt_set), .clr(pkt_clr), .q(pkt_q));
    tx_status_flag #(.W(NFATAL)) u_fatal (
        .clk(clk), .rst_n(rst_n), .set(fat_set), .clr(fat_clr), .q(fat_q));
    tx_status_flag #(.W(NMISC)) u_misc (
        .clk(clk), .rst_n(rst_n), .set(misc_set), .clr(misc_clr), .q(misc_q));

    tx_status_link_sync #(.STAGES(LINK_STAGES)) u_link (
        .clk(clk), .rst_n(rst_n), .pin_n(link_n_pin),
        .link_ok(link_ok), .change(link_irq));

    // Purpose: assemble the live word; unused positions read zero.
    always_comb begin
        status                     = '0;
        status[B_XDEF:B_OK]        = pkt_q;
        status[B_UNRN:B_LCAR]      = fat_q;
        status[B_CROL]             = misc_q[0];
        status[B_ROVR]             = misc_q[1];
        status[B_LINK]             = link_ok;
        status[B_TXEN]             = txen;
    end

    assign ovr_int  = misc_q[2];
    assign txen_clr = |fat_set;

    tx_status_snap #(.W(STAT_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .capture(txen & pkt_done), .din(status),
        .snap_word(snap_word), .snap_valid(snap_valid));
endmodule

// File: rtl/tx_status_chk.sv
// Module: property checker for tx_status_reg, attached by bind below.
// Assumes: the bit positions of tx_status_pkg.
module tx_status_chk
    import tx_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              txen,
    input logic              txen_set,
    input logic              pkt_done,
    input logic              ev_deferred,
    input logic              ev_underrun,
    input logic              ev_late_col,
    input logic              ev_ctr_max,
    input logic              ev_rx_overrun,
    input logic              ovr_int_clr,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] snap_word,
    input logic              snap_valid,
    input logic              txen_clr,
    input logic              link_irq,
    input logic              ovr_int
);
    p_snap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && pkt_done) |=> (snap_valid && snap_word == $past(status)));
    p_underrun_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && ev_underrun) |=> status[B_UNRN]);
    p_underrun_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_UNRN] && !txen_set) |=> status[B_UNRN]);
    p_latcol_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && ev_late_col) |-> txen_clr);
    p_pkt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txen && pkt_done && !ev_deferred) |=> !status[B_DEFR]);
    p_link_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_irq |-> (status[B_LINK] != $past(status[B_LINK])));
    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> (status[B_ROVR] && ovr_int));
    p_ovr_int_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_int && !ovr_int_clr) |=> ovr_int);
    p_rollover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ctr_max |=> status[B_CROL]);
    p_hold_txen_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !txen |=> (status[B_XDEF:B_OK] == $past(status[B_XDEF:B_OK])));
    p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1:B_TXEN+1] == '0);
endmodule

bind tx_status_reg tx_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .txen(txen), .txen_set(txen_set),
    .pkt_done(pkt_done), .ev_deferred(ev_deferred), .ev_underrun(ev_underrun),
    .ev_late_col(ev_late_col), .ev_ctr_max(ev_ctr_max),
    .ev_rx_overrun(ev_rx_overrun), .ovr_int_clr(ovr_int_clr),
    .status(status), .snap_word(snap_word), .snap_valid(snap_valid),
    .txen_clr(txen_clr), .link_irq(link_irq), .ovr_int(ovr_int));

// File: tb/tb_tx_status_reg.sv
// Bench: behavioural reference model compared with the DUT every clock.
module tb_tx_status_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txen = 1'b0;
    logic txen_set = 0, pkt_done = 0, ev_tx_ok = 0, ev_single_col = 0;
    logic ev_multi_col = 0, ev_multicast = 0, ev_broadcast = 0, ev_deferred = 0;
    logic ev_exc_defer = 0, carr_mon_en = 0, ev_lost_carr = 0, ev_late_col = 0;
    logic ev_underrun = 0, ev_ctr_max = 0, ctr_read = 0, ev_rx_overrun = 0;
    logic rx_preamble = 0, ovr_int_clr = 0, link_n_pin = 1;
    logic [15:0] status, snap_word;
    logic snap_valid, txen_clr, link_irq, ovr_int;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    // reference state
    bit [15:0] m_stat;
    bit [15:0] m_snap;
    bit m_snap_v, m_ovr_int, m_irq;
    bit h1, h2, hprev;

    always #4 clk = ~clk;

    tx_status_reg dut (
        .clk(clk), .rst_n(rst_n), .txen(txen), .txen_set(txen_set),
        .pkt_done(pkt_done), .ev_tx_ok(ev_tx_ok), .ev_single_col(ev_single_col),
        .ev_multi_col(ev_multi_col), .ev_multicast(ev_multicast),
        .ev_broadcast(ev_broadcast), .ev_deferred(ev_deferred),
        .ev_exc_defer(ev_exc_defer), .carr_mon_en(carr_mon_en),
        .ev_lost_carr(ev_lost_carr), .ev_late_col(ev_late_col),
        .ev_underrun(ev_underrun), .ev_ctr_max(ev_ctr_max), .ctr_read(ctr_read),
        .ev_rx_overrun(ev_rx_overrun), .rx_preamble(rx_preamble),
        .ovr_int_clr(ovr_int_clr), .link_n_pin(link_n_pin),
        .status(status), .snap_word(snap_word), .snap_valid(snap_valid),
        .txen_clr(txen_clr), .link_irq(link_irq), .ovr_int(ovr_int));

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int b);
        if (b <= 6) return "R5";
        case (b)
            7: return "R4";
            8: return "R3";
            9: return "R2";
            10: return "R9";
            11: return "R7";
            12: return "R6";
            default: return "R12";
        endcase
    endfunction

    function automatic bit exp_clr();
        return txen & (ev_underrun | ev_late_col | (ev_lost_carr & carr_mon_en));
    endfunction

    // Reference model: next state from the requirements, one edge at a time.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_snap = '0; m_snap_v = 0; m_ovr_int = 0; m_irq = 0;
            h1 = 1; h2 = 1; hprev = 1;
            cmp_on = 1;
        end else begin
            bit [15:0] old;
            bit [6:0] pset;
            old = m_stat;
            old[13] = txen;
            m_snap_v = txen & pkt_done;               // R1
            if (m_snap_v) m_snap = old;
            pset = {ev_exc_defer, ev_deferred, ev_broadcast, ev_multicast,
                    ev_multi_col, ev_single_col, ev_tx_ok};
            for (int i = 0; i < 7; i++) begin         // R5, R10, R11
                if (txen && pset[i]) m_stat[i] = 1;
                else if (txen && pkt_done) m_stat[i] = 0;
            end
            if (txen && ev_lost_carr && carr_mon_en) m_stat[7] = 1;   // R4
            else if (txen_set) m_stat[7] = 0;
            if (txen && ev_late_col) m_stat[8] = 1;                   // R3
            else if (txen_set) m_stat[8] = 0;
            if (txen && ev_underrun) m_stat[9] = 1;                   // R2
            else if (txen_set) m_stat[9] = 0;
            if (ev_ctr_max) m_stat[10] = 1; else if (ctr_read) m_stat[10] = 0;       // R9
            if (ev_rx_overrun) m_stat[11] = 1; else if (rx_preamble) m_stat[11] = 0; // R7
            if (ev_rx_overrun) m_ovr_int = 1; else if (ovr_int_clr) m_ovr_int = 0;   // R8
            hprev = h2; h2 = h1; h1 = link_n_pin;                     // R6
            m_stat[12] = ~h2;
            m_irq = (h2 != hprev);
        end
        // environment: the control register holding transmit enable
        if (txen_set) txen <= 1'b1;
        else if (exp_clr()) txen <= 1'b0;
    end

    // Compare every output mid-cycle.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit [15:0] e;
            e = m_stat;
            e[13] = txen;
            for (int b = 0; b < 16; b++)
                if (status[b] !== e[b]) chk(req_of(b), $sformatf("status[%0d]", b), {15'd0, status[b]}, {15'd0, e[b]});
            checks++;
            chk("R1", "snap_valid", {15'd0, snap_valid}, {15'd0, m_snap_v});
            if (m_snap_v) chk("R1", "snap_word", snap_word, m_snap);
            chk("R2", "txen_clr", {15'd0, txen_clr}, {15'd0, exp_clr()});
            chk("R6", "link_irq", {15'd0, link_irq}, {15'd0, m_irq});
            chk("R8", "ovr_int", {15'd0, ovr_int}, {15'd0, m_ovr_int});
        end
    end

    task automatic step();
        @(posedge clk); #1;
        {txen_set, pkt_done, ev_tx_ok, ev_single_col, ev_multi_col, ev_multicast,
         ev_broadcast, ev_deferred, ev_exc_defer, ev_lost_carr, ev_late_col,
         ev_underrun, ev_ctr_max, ctr_read, ev_rx_overrun, rx_preamble,
         ovr_int_clr} = '0;
    endtask

    task automatic mid_chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        @(negedge clk); #1;
        chk(req, what, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        mid_chk("R13", "status after reset", status, 16'h0000);
        mid_chk("R13", "outputs after reset", {12'd0, snap_valid, txen_clr, link_irq, ovr_int}, 16'h0);
        @(posedge clk); #1; rst_n = 1;
        step();
        txen_set = 1; step(); step();
        // normal packet
        ev_deferred = 1; ev_single_col = 1; step();
        ev_tx_ok = 1; step();
        pkt_done = 1; step();
        mid_chk("R1", "snapshot of first packet", snap_word, 16'h2023);
        mid_chk("R5", "flags cleared after packet", status & 16'h007f, 16'h0000);
        // broadcast, multi collision, excessive deferral
        ev_broadcast = 1; ev_multi_col = 1; ev_exc_defer = 1; step();
        ev_multicast = 1; step();
        pkt_done = 1; ev_tx_ok = 1; step();   // R11: set wins over packet clear
        mid_chk("R11", "tx_ok survives same-cycle clear", status & 16'h007f, 16'h0001);
        pkt_done = 1; step(); step();
        // underrun, events while disabled
        ev_single_col = 1; step();
        ev_underrun = 1; step(); step();
        ev_tx_ok = 1; ev_broadcast = 1; pkt_done = 1; step();
        mid_chk("R10", "pkt flags held with txen low", status & 16'h007f, 16'h0002);
        mid_chk("R10", "no snapshot with txen low", {15'd0, snap_valid}, 16'h0);
        txen_set = 1; step(); step();
        mid_chk("R2", "underrun cleared by re-enable", {15'd0, status[9]}, 16'h0);
        // late collision
        ev_late_col = 1; step(); step();
        txen_set = 1; step();
        // lost carrier, monitor off then on
        ev_lost_carr = 1; step();
        mid_chk("R4", "lost carrier ignored unmonitored", {15'd0, status[7]}, 16'h0);
        carr_mon_en = 1; ev_lost_carr = 1; step(); step();
        mid_chk("R4", "lost carrier set", {15'd0, status[7]}, 16'h1);
        txen_set = 1; step(); carr_mon_en = 0;
        // link pin
        link_n_pin = 0; repeat (4) step();
        mid_chk("R6", "link ok after sync", {15'd0, status[12]}, 16'h1);
        link_n_pin = 1; repeat (4) step();
        // rx overrun and interrupt status
        ev_rx_overrun = 1; step();
        rx_preamble = 1; step();
        mid_chk("R8", "interrupt stays after preamble", {15'd0, ovr_int}, 16'h1);
        ev_rx_overrun = 1; rx_preamble = 1; ovr_int_clr = 1; step();  // R11
        ovr_int_clr = 1; step();
        // counter rollover
        ev_ctr_max = 1; step();
        ev_ctr_max = 1; ctr_read = 1; step();
        ctr_read = 1; step();
        mid_chk("R9", "rollover cleared by read", {15'd0, status[10]}, 16'h0);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            pkt_done      = ($urandom_range(0, 9) == 0);
            ev_tx_ok      = ($urandom_range(0, 7) == 0);
            ev_single_col = ($urandom_range(0, 11) == 0);
            ev_multi_col  = ($urandom_range(0, 11) == 0);
            ev_multicast  = ($urandom_range(0, 11) == 0);
            ev_broadcast  = ($urandom_range(0, 11) == 0);
            ev_deferred   = ($urandom_range(0, 11) == 0);
            ev_exc_defer  = ($urandom_range(0, 15) == 0);
            ev_lost_carr  = ($urandom_range(0, 63) == 0);
            ev_late_col   = ($urandom_range(0, 63) == 0);
            ev_underrun   = ($urandom_range(0, 63) == 0);
            ev_ctr_max    = ($urandom_range(0, 15) == 0);
            ctr_read      = ($urandom_range(0, 15) == 0);
            ev_rx_overrun = ($urandom_range(0, 31) == 0);
            rx_preamble   = ($urandom_range(0, 15) == 0);
            ovr_int_clr   = ($urandom_range(0, 15) == 0);
            txen_set      = !txen && ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 63) == 0) carr_mon_en = ~carr_mon_en;
            if ($urandom_range(0, 31) == 0) link_n_pin = ~link_n_pin;
            step();
        end
        repeat (3) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule